// File: doc/BRIEF.md
# Authenticated Scratchpad Copy Controller

This block guards every write into a small register-modelled protected memory. The memory has four data pages of 32 bytes each, one 8-byte register page and one 8-byte secret. Nothing reaches these targets directly. The host first fills an 8-byte scratchpad one byte at a time and may read it back unchanged. It then issues a copy request, which moves the whole scratchpad into the 8-byte row named by the last scratchpad write address.

A copy to a data page or to the register page waits for an externally computed 160-bit authorization code, which arrives with a valid strobe. The copy commits only if that code equals the expected code, which is also an input. Loading the secret needs no code. The secret is never visible on the host read port; it is offered only to the hash engine through a dedicated output. A protection setting can lock page 0 alone or every target. A separate mode makes page 1 accept only 1-to-0 bit changes.

Each copy ends with exactly one single-cycle result pulse: committed, code mismatch, or write-protected.

Top module: `scp_copy_ctrl`

## Requirements
- R1: After reset, all result pulses and `copy_busy` are low, the scratchpad reads zero, every readable memory byte reads zero and `key_out` is zero.
- R2: A scratchpad write stores `sp_wr_data` in the byte selected by `sp_wr_addr[2:0]`. It also sets the copy target row to `sp_wr_addr[7:3]`. `sp_rd_sel` reads any byte back unchanged, with no delay.
- R3: Target addresses 0x00–0x7F are the data pages, 32 bytes per page. A copy to a data row raises `copy_busy`. When `mac_valid` arrives with `mac_got == mac_want`, the copy writes scratchpad byte i to row byte i, and `st_ok` pulses in the cycle after the strobe.
- R4: If `mac_valid` arrives with a mismatching code, the target row is left unchanged, `st_badmac` pulses in the cycle after the strobe and `copy_busy` drops.
- R5: A copy to the secret row (addresses 0x88–0x8F) needs no code. It commits at once, `st_ok` pulses in the cycle after the request and `key_out` takes the scratchpad value. Memory reads of 0x88–0x8F always return zero.
- R6: `prot_mode` 01 locks page 0 (0x00–0x1F). `prot_mode` 10 or 11 locks every target. Addresses 0x90 and above are always locked. A copy to a locked row pulses `st_prot` in the cycle after the request, never raises `copy_busy` and changes nothing.
- R7: While `p1_and_mode` is 1, a commit to page 1 (0x20–0x3F) stores the old value ANDed with the scratchpad value. Other pages are overwritten as usual.
- R8: While `copy_busy` is high, scratchpad writes and further copy requests are ignored.
- R9: If no `mac_valid` arrives within TIMEOUT cycles of acceptance, `st_badmac` pulses in the cycle after the TIMEOUT-th clock edge and the target is unchanged. A `mac_valid` at that same edge takes precedence.
- R10: A scratchpad write presented in the same cycle as an accepted copy request is discarded, and the copy uses the earlier scratchpad contents.
- R11: Each copy produces exactly one result pulse, one cycle long, and at most one of `st_ok`, `st_badmac`, `st_prot` is high at any time.
- R12: The register page (0x80–0x87) is committed only with a matching code, and it is readable through the memory read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_wr_en | input | 1 | Scratchpad byte write strobe |
| sp_wr_addr | input | 8 | Target address: row in [7:3], byte in [2:0] |
| sp_wr_data | input | 8 | Byte to write into the scratchpad |
| sp_rd_sel | input | 3 | Scratchpad byte to read back |
| sp_rd_data | output | 8 | Scratchpad byte read-back |
| copy_req | input | 1 | Request to copy the scratchpad to the target row |
| prot_mode | input | 2 | 00 none, 01 page 0 locked, 1x all targets locked |
| p1_and_mode | input | 1 | Page 1 accepts only 1-to-0 changes |
| mac_valid | input | 1 | Authorization code strobe |
| mac_got | input | 160 | Code supplied by the host |
| mac_want | input | 160 | Expected code from the hash engine |
| mem_rd_addr | input | 8 | Memory byte read address |
| mem_rd_data | output | 8 | Memory byte; zero for the secret and unused space |
| key_out | output | 64 | Secret value for the hash engine |
| copy_busy | output | 1 | Copy waiting for a code |
| st_ok | output | 1 | Pulse: copy committed |
| st_badmac | output | 1 | Pulse: code mismatch or timeout |
| st_prot | output | 1 | Pulse: target write-protected |

## Verification
The sharpest coincidence is a scratchpad write that lands in the same cycle as the copy request that is accepted. The bench provokes it by raising `copy_req` and `sp_wr_en` together on an idle block. It judges the outcome by reading the committed row and the scratchpad back, both of which must still hold the older byte. A second race places a matching `mac_valid` exactly on the clock edge where the timeout would expire. The bench expects `st_ok` rather than `st_badmac` there.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int ADDR_W        = 8;
    localparam int ROW_BYTES     = 8;
    localparam int BSEL_W        = $clog2(ROW_BYTES);
    localparam int ROW_W         = ADDR_W - BSEL_W;
    localparam int ROW_BITS      = ROW_BYTES * 8;
    localparam int PAGES         = 4;
    localparam int PAGE_BYTES    = 32;
    localparam int ROWS_PER_PAGE = PAGE_BYTES / ROW_BYTES;
    localparam int DATA_ROWS     = PAGES * ROWS_PER_PAGE;
    localparam int NUM_ROWS      = DATA_ROWS + 2;

    localparam logic [ROW_W-1:0] REG_ROW   = ROW_W'(DATA_ROWS);
    localparam logic [ROW_W-1:0] KEY_ROW   = ROW_W'(DATA_ROWS + 1);
    localparam logic [ROW_W-1:0] P1_FIRST  = ROW_W'(ROWS_PER_PAGE);
    localparam logic [ROW_W-1:0] P2_FIRST  = ROW_W'(2 * ROWS_PER_PAGE);

    typedef logic [ROW_W-1:0]    row_t;
    typedef logic [ROW_BITS-1:0] line_t;

    typedef enum logic [1:0] {
        LOCK_NONE  = 2'b00,
        LOCK_PAGE0 = 2'b01,
        LOCK_ALL   = 2'b10,
        LOCK_ALL2  = 2'b11
    } lock_e;

    typedef enum logic {
        CP_IDLE = 1'b0,
        CP_WAIT = 1'b1
    } cp_state_e;

    typedef struct packed {
        logic ok;
        logic badmac;
        logic prot;
    } cp_result_t;

    function automatic logic row_locked(input row_t row, input lock_e mode);
        if (row > KEY_ROW)                     return 1'b1;
        if (mode == LOCK_ALL || mode == LOCK_ALL2) return 1'b1;
        if (mode == LOCK_PAGE0 && row < P1_FIRST)  return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic row_in_p1(input row_t row);
        return (row >= P1_FIRST) && (row < P2_FIRST);
    endfunction

    function automatic line_t merge_line(input line_t old_v, input line_t new_v,
                                         input logic and_only);
        return and_only ? (old_v & new_v) : new_v;
    endfunction

endpackage

// File: rtl/scp_scratchpad.sv
module scp_scratchpad
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [BSEL_W-1:0] rd_sel,
    output logic [7:0]        rd_data,
    output row_t              row_q,
    output line_t             line_q
);

    logic [7:0] bytes_q [ROW_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROW_BYTES; i++) bytes_q[i] <= '0;
            row_q <= '0;
        end else if (wr_en) begin
            bytes_q[wr_addr[BSEL_W-1:0]] <= wr_data;
            row_q <= wr_addr[ADDR_W-1:BSEL_W];
        end
    end

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_pack
        assign line_q[8*g +: 8] = bytes_q[g];
    end

    assign rd_data = bytes_q[rd_sel];

endmodule

// File: rtl/scp_mem_array.sv
module scp_mem_array
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  row_t              wr_row,
    input  line_t             wr_line,
    input  logic              p1_and,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output line_t             key_q
);

    line_t mem_q [NUM_ROWS];
    row_t  rd_row;
    line_t rd_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ROWS; i++) mem_q[i] <= '0;
        end else if (we && wr_row <= KEY_ROW) begin
            mem_q[wr_row] <= merge_line(mem_q[wr_row], wr_line,
                                        p1_and && row_in_p1(wr_row));
        end
    end

    assign rd_row  = rd_addr[ADDR_W-1:BSEL_W];
    assign rd_line = (rd_row < KEY_ROW) ? mem_q[rd_row] : '0;
    assign rd_data = rd_line[8*rd_addr[BSEL_W-1:0] +: 8];
    assign key_q   = mem_q[KEY_ROW];

endmodule

// File: rtl/scp_copy_fsm.sv
module scp_copy_fsm
    import scp_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       copy_req,
    input  row_t       row,
    input  lock_e      mode,
    input  logic       mac_valid,
    input  logic       mac_hit,
    output logic       accept,
    output logic       commit,
    output logic       busy,
    output cp_result_t result_q
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    cp_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    cp_result_t       result_d;

    assign accept = (state_q == CP_IDLE) && copy_req;
    assign busy   = (state_q == CP_WAIT);

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        result_d = '0;
        commit   = 1'b0;
        case (state_q)
            CP_IDLE: begin
                if (copy_req) begin
                    if (row_locked(row, mode)) begin
                        result_d.prot = 1'b1;
                    end else if (row == KEY_ROW) begin
                        commit      = 1'b1;
                        result_d.ok = 1'b1;
                    end else begin
                        state_d = CP_WAIT;
                        cnt_d   = '0;
                    end
                end
            end
            CP_WAIT: begin
                if (mac_valid) begin
                    state_d = CP_IDLE;
                    if (mac_hit) begin
                        commit      = 1'b1;
                        result_d.ok = 1'b1;
                    end else begin
                        result_d.badmac = 1'b1;
                    end
                end else if (cnt_q == CNT_LAST) begin
                    state_d         = CP_IDLE;
                    result_d.badmac = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CP_IDLE;
            cnt_q    <= '0;
            result_q <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            result_q <= result_d;
        end
    end

endmodule

// File: rtl/scp_copy_ctrl.sv
module scp_copy_ctrl
    import scp_pkg::*;
#(
    parameter int MAC_W   = 160,
    parameter int TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sp_wr_en,
    input  logic [7:0]        sp_wr_addr,
    input  logic [7:0]        sp_wr_data,
    input  logic [2:0]        sp_rd_sel,
    output logic [7:0]        sp_rd_data,
    input  logic              copy_req,
    input  logic [1:0]        prot_mode,
    input  logic              p1_and_mode,
    input  logic              mac_valid,
    input  logic [MAC_W-1:0]  mac_got,
    input  logic [MAC_W-1:0]  mac_want,
    input  logic [7:0]        mem_rd_addr,
    output logic [7:0]        mem_rd_data,
    output logic [63:0]       key_out,
    output logic              copy_busy,
    output logic              st_ok,
    output logic              st_badmac,
    output logic              st_prot
);

    row_t       sp_row;
    line_t      sp_data;
    logic       accept, commit, sp_we;
    cp_result_t result;

    assign sp_we = sp_wr_en && !copy_busy && !accept;

    scp_scratchpad u_sp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sp_we),
        .wr_addr (sp_wr_addr),
        .wr_data (sp_wr_data),
        .rd_sel  (sp_rd_sel),
        .rd_data (sp_rd_data),
        .row_q   (sp_row),
        .line_q  (sp_data)
    );

    scp_copy_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .copy_req  (copy_req),
        .row       (sp_row),
        .mode      (lock_e'(prot_mode)),
        .mac_valid (mac_valid),
        .mac_hit   (mac_got == mac_want),
        .accept    (accept),
        .commit    (commit),
        .busy      (copy_busy),
        .result_q  (result)
    );

    scp_mem_array u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (commit),
        .wr_row  (sp_row),
        .wr_line (sp_data),
        .p1_and  (p1_and_mode),
        .rd_addr (mem_rd_addr),
        .rd_data (mem_rd_data),
        .key_q   (key_out)
    );

    assign st_ok     = result.ok;
    assign st_badmac = result.badmac;
    assign st_prot   = result.prot;

endmodule

// File: rtl/scp_copy_ctrl_chk.sv
module scp_copy_ctrl_chk #(
    parameter int MAC_W = 160
) (
    input logic             clk,
    input logic             rst,
    input logic             copy_req,
    input logic             copy_busy,
    input logic             sp_wr_en,
    input logic [63:0]      sp_q,
    input logic [1:0]       prot_mode,
    input logic             mac_valid,
    input logic [MAC_W-1:0] mac_got,
    input logic [MAC_W-1:0] mac_want,
    input logic             st_ok,
    input logic             st_badmac,
    input logic             st_prot
);

    AST_GOOD_CODE_COMMITS: assert property (@(posedge clk) disable iff (rst)
        copy_busy && mac_valid && (mac_got == mac_want) |=> st_ok && !copy_busy); // R3

    AST_BAD_CODE_REJECTS: assert property (@(posedge clk) disable iff (rst)
        copy_busy && mac_valid && (mac_got != mac_want) |=> st_badmac && !copy_busy); // R4

    AST_LOCKED_ALL_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        !copy_busy && copy_req && prot_mode[1] |=> st_prot && !copy_busy); // R6

    AST_BUSY_FREEZES_SP: assert property (@(posedge clk) disable iff (rst)
        copy_busy && sp_wr_en |=> $stable(sp_q)); // R8

    AST_BUSY_ENDS_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
        $fell(copy_busy) |-> (st_ok || st_badmac)); // R9

    AST_ACCEPT_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !copy_busy && copy_req && sp_wr_en |=> $stable(sp_q)); // R10

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_ok, st_badmac, st_prot})); // R11

endmodule

bind scp_copy_ctrl scp_copy_ctrl_chk #(.MAC_W(MAC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .copy_req  (copy_req),
    .copy_busy (copy_busy),
    .sp_wr_en  (sp_wr_en),
    .sp_q      (sp_data),
    .prot_mode (prot_mode),
    .mac_valid (mac_valid),
    .mac_got   (mac_got),
    .mac_want  (mac_want),
    .st_ok     (st_ok),
    .st_badmac (st_badmac),
    .st_prot   (st_prot)
);

// File: tb/scp_copy_ctrl_tb_top.sv
module scp_copy_ctrl_tb_top;

    localparam int TO = 16;
    localparam int MW = 160;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sp_wr_en = 1'b0;
    logic [7:0]    sp_wr_addr = '0;
    logic [7:0]    sp_wr_data = '0;
    logic [2:0]    sp_rd_sel = '0;
    logic [7:0]    sp_rd_data;
    logic          copy_req = 1'b0;
    logic [1:0]    prot_mode = 2'b00;
    logic          p1_and_mode = 1'b0;
    logic          mac_valid = 1'b0;
    logic [MW-1:0] mac_want = {5{32'hC0DE_5A17}};
    logic [MW-1:0] mac_got = '0;
    logic [7:0]    mem_rd_addr = '0;
    logic [7:0]    mem_rd_data;
    logic [63:0]   key_out;
    logic          copy_busy, st_ok, st_badmac, st_prot;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    scp_copy_ctrl #(.MAC_W(MW), .TIMEOUT(TO)) dut_i (
        .clk(clk), .rst(rst), .sp_wr_en(sp_wr_en), .sp_wr_addr(sp_wr_addr),
        .sp_wr_data(sp_wr_data), .sp_rd_sel(sp_rd_sel), .sp_rd_data(sp_rd_data),
        .copy_req(copy_req), .prot_mode(prot_mode), .p1_and_mode(p1_and_mode),
        .mac_valid(mac_valid), .mac_got(mac_got), .mac_want(mac_want),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .key_out(key_out),
        .copy_busy(copy_busy), .st_ok(st_ok), .st_badmac(st_badmac), .st_prot(st_prot)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sp_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        sp_wr_en = 1'b1; sp_wr_addr = addr; sp_wr_data = data;
        @(negedge clk);
        sp_wr_en = 1'b0;
    endtask

    task automatic fill_row(input logic [7:0] base, input logic [63:0] v);
        for (int i = 0; i < 8; i++) sp_write(base + 8'(i), v[8*i +: 8]);
    endtask

    task automatic read_mem(input logic [7:0] base, output logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            mem_rd_addr = base + 8'(i);
            #1 v[8*i +: 8] = mem_rd_data;
        end
    endtask

    task automatic read_sp(output logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            sp_rd_sel = 3'(i);
            #1 v[8*i +: 8] = sp_rd_data;
        end
    endtask

    // result bits: {ok, badmac, prot}
    task automatic do_copy(input bit good, output logic [2:0] st, output logic was_busy);
        @(negedge clk);
        copy_req = 1'b1;
        @(negedge clk);
        copy_req = 1'b0;
        was_busy = copy_busy;
        if (copy_busy) begin
            mac_got   = good ? mac_want : (mac_want ^ {{(MW-1){1'b0}}, 1'b1});
            mac_valid = 1'b1;
            @(negedge clk);
            mac_valid = 1'b0;
        end
        st = {st_ok, st_badmac, st_prot};
        @(negedge clk);
        check("R11 pulse lasts one cycle", {61'd0, st_ok, st_badmac, st_prot}, 64'd0);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status/busy", {60'd0, st_ok, st_badmac, st_prot, copy_busy}, 64'd0);
        read_sp(v);   check("R1 scratchpad", v, 64'd0);
        read_mem(8'h00, v); check("R1 memory", v, 64'd0);
        check("R1 key", key_out, 64'd0);
    endtask

    task automatic t_sp_and_copy();
        logic [63:0] v; logic [2:0] st; logic b;
        fill_row(8'h08, 64'h8877_6655_4433_2211);
        read_sp(v); check("R2 readback", v, 64'h8877_6655_4433_2211);
        sp_rd_sel = 3'd2; #1 check("R2 byte 2", {56'd0, sp_rd_data}, 64'h33);
        do_copy(1'b1, st, b);
        check("R3 waits for code", {63'd0, b}, 64'd1);
        check("R3 ok pulse", {61'd0, st}, 64'b100);
        read_mem(8'h08, v); check("R3 row written", v, 64'h8877_6655_4433_2211);
    endtask

    task automatic t_busy_ignores();
        logic [63:0] v;
        fill_row(8'h18, 64'hA1A2_A3A4_A5A6_A7A8);
        @(negedge clk); copy_req = 1'b1;
        @(negedge clk); copy_req = 1'b0;
        check("R8 busy", {63'd0, copy_busy}, 64'd1);
        sp_write(8'h1A, 8'hEE);
        read_sp(v); check("R8 write ignored", v, 64'hA1A2_A3A4_A5A6_A7A8);
        sp_write(8'h48, 8'h55);
        read_sp(v); check("R8 other-row write ignored", v, 64'hA1A2_A3A4_A5A6_A7A8);
        @(negedge clk); copy_req = 1'b1;
        @(negedge clk); copy_req = 1'b0;
        mac_got = mac_want; mac_valid = 1'b1;
        @(negedge clk); mac_valid = 1'b0;
        check("R8 resolves once", {61'd0, st_ok, st_badmac, st_prot}, 64'b100);
        @(negedge clk);
        check("R8 second request ignored", {60'd0, copy_busy, st_ok, st_badmac, st_prot}, 64'd0);
        read_mem(8'h18, v); check("R8 row holds first data", v, 64'hA1A2_A3A4_A5A6_A7A8);
    endtask

    task automatic t_mismatch();
        logic [63:0] v; logic [2:0] st; logic b;
        fill_row(8'h10, 64'h0F0F_1234_5678_9ABC);
        do_copy(1'b0, st, b);
        check("R4 badmac pulse", {61'd0, st}, 64'b010);
        read_mem(8'h10, v); check("R4 row unchanged", v, 64'd0);
    endtask

    task automatic t_secret_and_reg();
        logic [63:0] v; logic [2:0] st; logic b;
        fill_row(8'h88, 64'h5EC2_E7AA_0011_2233);
        do_copy(1'b0, st, b);
        check("R5 no wait", {63'd0, b}, 64'd0);
        check("R5 ok pulse", {61'd0, st}, 64'b100);
        check("R5 key loaded", key_out, 64'h5EC2_E7AA_0011_2233);
        read_mem(8'h88, v); check("R5 secret hidden", v, 64'd0);
        fill_row(8'h80, 64'hDEAD_BEEF_CAFE_0042);
        do_copy(1'b1, st, b);
        check("R12 waits for code", {63'd0, b}, 64'd1);
        check("R12 ok", {61'd0, st}, 64'b100);
        read_mem(8'h80, v); check("R12 readable", v, 64'hDEAD_BEEF_CAFE_0042);
    endtask

    task automatic t_protect();
        logic [63:0] v; logic [2:0] st; logic b;
        prot_mode = 2'b01;
        fill_row(8'h00, 64'h1111_2222_3333_4444);
        do_copy(1'b1, st, b);
        check("R6 page0 no wait", {63'd0, b}, 64'd0);
        check("R6 page0 prot", {61'd0, st}, 64'b001);
        read_mem(8'h00, v); check("R6 page0 unchanged", v, 64'd0);
        fill_row(8'h20, 64'hF0F0_FF00_CC33_AA55);
        do_copy(1'b1, st, b);
        check("R6 page1 open under page0 lock", {61'd0, st}, 64'b100);
        prot_mode = 2'b10;
        fill_row(8'h88, 64'h1234_1234_1234_1234);
        do_copy(1'b1, st, b);
        check("R6 secret locked", {61'd0, st}, 64'b001);
        check("R6 key kept", key_out, 64'h5EC2_E7AA_0011_2233);
        prot_mode = 2'b11;
        fill_row(8'h80, 64'h0);
        do_copy(1'b1, st, b);
        check("R6 reg locked", {61'd0, st}, 64'b001);
        read_mem(8'h80, v); check("R6 reg kept", v, 64'hDEAD_BEEF_CAFE_0042);
        prot_mode = 2'b00;
        fill_row(8'h90, 64'h77);
        do_copy(1'b1, st, b);
        check("R6 unused space locked", {62'd0, st[0], b}, 64'b10);
    endtask

    task automatic t_and_mode();
        logic [63:0] v; logic [2:0] st; logic b;
        p1_and_mode = 1'b1;
        fill_row(8'h20, 64'h3C3C_0FF0_FFFF_0000);
        do_copy(1'b1, st, b);
        read_mem(8'h20, v);
        check("R7 page1 AND", v, 64'hF0F0_FF00_CC33_AA55 & 64'h3C3C_0FF0_FFFF_0000);
        fill_row(8'h40, 64'hFFFF_0000_FFFF_0000);
        do_copy(1'b1, st, b);
        fill_row(8'h40, 64'h00FF_00FF_00FF_00FF);
        do_copy(1'b1, st, b);
        read_mem(8'h40, v); check("R7 page2 overwrite", v, 64'h00FF_00FF_00FF_00FF);
        p1_and_mode = 1'b0;
    endtask

    task automatic t_timeout();
        logic [63:0] v; logic early_bad;
        fill_row(8'h30, 64'h7E57_7E57_7E57_7E57);
        @(negedge clk); copy_req = 1'b1;
        @(negedge clk); copy_req = 1'b0;
        early_bad = 1'b0;
        for (int j = 1; j <= TO; j++) begin
            @(negedge clk);
            if (j < TO && (st_badmac || !copy_busy)) early_bad = 1'b1;
        end
        check("R9 no early result", {63'd0, early_bad}, 64'd0);
        check("R9 timeout result", {62'd0, st_badmac, copy_busy}, 64'b10);
        read_mem(8'h30, v); check("R9 row unchanged", v, 64'd0);
        @(negedge clk); copy_req = 1'b1;
        @(negedge clk); copy_req = 1'b0;
        for (int j = 1; j < TO; j++) @(negedge clk);
        mac_got = mac_want; mac_valid = 1'b1;
        @(negedge clk); mac_valid = 1'b0;
        check("R9 code beats timeout", {62'd0, st_ok, st_badmac}, 64'b10);
        read_mem(8'h30, v); check("R9 late commit", v, 64'h7E57_7E57_7E57_7E57);
    endtask

    task automatic t_same_cycle();
        logic [63:0] v;
        fill_row(8'h50, 64'h0102_0304_0506_0708);
        @(negedge clk);
        copy_req = 1'b1; sp_wr_en = 1'b1; sp_wr_addr = 8'h50; sp_wr_data = 8'h99;
        @(negedge clk);
        copy_req = 1'b0; sp_wr_en = 1'b0;
        mac_got = mac_want; mac_valid = 1'b1;
        @(negedge clk); mac_valid = 1'b0;
        check("R10 copy ok", {63'd0, st_ok}, 64'd1);
        read_mem(8'h50, v); check("R10 old data copied", v, 64'h0102_0304_0506_0708);
        sp_rd_sel = 3'd0; #1 check("R10 write dropped", {56'd0, sp_rd_data}, 64'h08);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_sp_and_copy();
        t_busy_ignores();
        t_mismatch();
        t_secret_and_reg();
        t_protect();
        t_and_mode();
        t_timeout();
        t_same_cycle();
        report();
        $finish;
    end

endmodule